// File: doc/BRIEF.md
# ROM-Selected Reference Divider

This block turns a free-running reference oscillator clock into a single-cycle strobe at the phase-comparison rate. The strobe is meant for the reference side of a frequency synthesizer's phase detector. The divide ratio is not held in a register. A 3-bit code picks one of eight fixed ratios from a small constant table: 8, 64, 128, 256, 512, 1024, 1160 and 2048. The table includes one ratio, 1160, that is not a power of two. The chosen entry, minus one, is loaded into a 12-bit down counter. A strobe is produced each time the counter reaches zero.

The code is looked at only when the counter reloads. Changing it while a period is in progress never shortens or lengthens that period. The new ratio starts with the next one. At board level the select lines carry pull-ups, so select lines left open read as code 7, which gives divide-by-2048. After reset the counter first loads the ratio selected at that moment and then runs.

Top module: `ref_ratio_divider`

## Requirements
- R1: The select code `ratio_sel` (bit 2 is the most significant) maps to these ratios: 0→8, 1→64, 2→128, 3→256, 4→512, 5→1024, 6→1160, 7→2048.
- R2: Every strobe on `ref_pulse` is high for exactly one clock cycle.
- R3: With a steady select code, consecutive rising edges of `ref_pulse` are exactly the selected ratio in clock cycles apart.
- R4: A select change made during a period leaves the length of that period unchanged. The period that follows uses the new ratio.
- R5: A select value that is present only between reloads has no effect on any period length.
- R6: While `rst_n` is low, `ref_pulse` is low. After release, the first strobe appears R cycles after the first active clock edge, where R is the ratio selected at that edge. That edge is the one that loads the counter.
- R7: Code 7, which is the level that open pulled-up select lines give, divides by 2048, the largest ratio in the table.
- R8: Code 6 divides by 1160, which is not a power of two, with the same exact period as the other codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 3 | Code that picks the divide ratio from the table |
| ref_pulse | output | 1 | One-cycle strobe at the divided rate |

## Verification
A bad table entry or a bad reload value shows up as a wrong strobe spacing as soon as the period after the faulty load ends, which takes at most 2048 cycles. A counter that samples the select code at the wrong moment changes the length of the period in which the code was changed, instead of the next one. A fault in the reset or priming path moves the first strobe away from R cycles after release. A strobe that lasts two cycles shows up one cycle after it rises.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

   localparam int unsigned SEL_BITS  = 3;
   localparam int unsigned CNT_BITS  = 12;
   localparam int unsigned MAX_RATIO = 2048;

   // Fixed ratio table: ascending order of code is behaviour (code 7 is the
   // pulled-up default and the largest ratio).
   function automatic int unsigned ratio_of(input int unsigned code);
      case (code)
         0:       ratio_of = 8;
         1:       ratio_of = 64;
         2:       ratio_of = 128;
         3:       ratio_of = 256;
         4:       ratio_of = 512;
         5:       ratio_of = 1024;
         6:       ratio_of = 1160;
         default: ratio_of = 2048;
      endcase
   endfunction

endpackage

// File: rtl/refdiv_rom.sv
module refdiv_rom #(
   parameter int unsigned SEL_W = refdiv_pkg::SEL_BITS,
   parameter int unsigned CNT_W = refdiv_pkg::CNT_BITS
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] term
);

   localparam int unsigned ENTRIES = 1 << SEL_W;

   logic [CNT_W-1:0] tbl [ENTRIES];

   // Each entry stores ratio-1 so the counter terminates at zero.
   for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
      assign tbl[i] = CNT_W'(refdiv_pkg::ratio_of(i) - 1);
   end

   assign term = tbl[sel];

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
   parameter int unsigned CNT_W = refdiv_pkg::CNT_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             primed,
   output logic             tc
);

   logic reload;

   assign tc     = primed && (cnt == '0);
   assign reload = !primed || (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         primed <= 1'b0;
      end else if (reload) begin
         cnt    <= load_val;
         primed <= 1'b1;
      end else begin
         cnt    <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/refdiv_pulse.sv
module refdiv_pulse #(
   parameter bit PULSE_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tc,
   output logic pulse
);

   if (PULSE_REG) begin : g_reg
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= tc;
      end
      assign pulse = q;
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign pulse     = tc;
   end

endmodule

// File: rtl/ref_ratio_divider.sv
module ref_ratio_divider #(
   parameter int unsigned SEL_W     = refdiv_pkg::SEL_BITS,
   parameter int unsigned CNT_W     = refdiv_pkg::CNT_BITS,
   parameter bit          PULSE_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] ratio_sel,
   output logic             ref_pulse
);

   if (SEL_W != 3) begin : g_bad_sel
      $error("ref_ratio_divider: table holds exactly eight entries, SEL_W must be 3");
   end
   if ((64'd1 << CNT_W) < 64'(refdiv_pkg::MAX_RATIO)) begin : g_bad_cnt
      $error("ref_ratio_divider: CNT_W too narrow for the largest ratio");
   end

   logic [CNT_W-1:0] term_w;
   logic [CNT_W-1:0] cnt_w;
   logic             primed_w;
   logic             tc_w;

   refdiv_rom #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_rom (
      .sel  (ratio_sel),
      .term (term_w)
   );

   refdiv_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_val (term_w),
      .cnt      (cnt_w),
      .primed   (primed_w),
      .tc       (tc_w)
   );

   refdiv_pulse #(.PULSE_REG(PULSE_REG)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .tc    (tc_w),
      .pulse (ref_pulse)
   );

endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
   parameter int unsigned CNT_W = refdiv_pkg::CNT_BITS
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_pulse,
   input logic [CNT_W-1:0] cnt,
   input logic             primed,
   input logic             tc,
   input logic [CNT_W-1:0] load_val
);

   localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(refdiv_pkg::MAX_RATIO - 1);

   // R2: strobe never lasts two cycles
   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse |=> !ref_pulse);

   // R4 / R5: reload takes the table entry present at the terminal edge
   p_reload_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> (cnt == $past(load_val)));

   // R3: between reloads the counter steps down by one
   p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !tc) |=> (cnt == $past(cnt) - 1'b1));

   // R6: first active edge loads the selected entry
   p_prime_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |=> (primed && cnt == $past(load_val)));

   // R6: no strobe before the counter is loaded
   p_quiet_unprimed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |-> !ref_pulse);

   // R1: counter never exceeds the largest table entry
   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TOP_VAL);

endmodule

bind ref_ratio_divider refdiv_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_pulse (ref_pulse),
   .cnt       (cnt_w),
   .primed    (primed_w),
   .tc        (tc_w),
   .load_val  (term_w)
);

// File: tb/ref_ratio_divider_test.sv
module ref_ratio_divider_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ratio_sel = 3'd7;
   logic       ref_pulse;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   ref_ratio_divider uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ratio_sel (ratio_sel),
      .ref_pulse (ref_pulse)
   );

   function automatic int exp_ratio(input int code);
      case (code)
         0: return 8;
         1: return 64;
         2: return 128;
         3: return 256;
         4: return 512;
         5: return 1024;
         6: return 1160;
         default: return 2048;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // Counts negedges until the strobe is seen; also checks that the strobe
   // was low on the first negedge (previous strobe one cycle wide, R2).
   task automatic wait_pulse(input int limit, input bit check_width, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (n == 1 && check_width)
            chk(ref_pulse == 1'b0, "R2 width", int'(ref_pulse), 0);
      end while (!ref_pulse && n < limit);
   endtask

   task automatic apply_reset(input logic [2:0] code);
      @(negedge clk);
      rst_n     = 1'b0;
      ratio_sel = code;
      repeat (3) begin
         @(negedge clk);
         chk(ref_pulse == 1'b0, "R6 reset low", int'(ref_pulse), 0);
      end
      rst_n = 1'b1;
   endtask

   // R1, R3, R6, R7, R8: every code, first strobe timing and period
   task automatic t_all_ratios();
      int n;
      for (int code = 0; code < 8; code++) begin
         apply_reset(3'(code));
         wait_pulse(5000, 1'b0, n);
         chk(n == exp_ratio(code) + 1, $sformatf("R6 first strobe code %0d", code),
             n, exp_ratio(code) + 1);
         wait_pulse(5000, 1'b1, n);
         if (code == 7)
            chk(n == 2048, "R7 default code period", n, 2048);
         else if (code == 6)
            chk(n == 1160, "R8 non-power-of-two period", n, 1160);
         else
            chk(n == exp_ratio(code), $sformatf("R1 R3 period code %0d", code),
                n, exp_ratio(code));
      end
   endtask

   // R4: change mid-run applies from the following period
   task automatic t_switch();
      int n;
      apply_reset(3'd0);
      wait_pulse(5000, 1'b0, n);
      ratio_sel = 3'd2;
      wait_pulse(5000, 1'b1, n);
      chk(n == 8, "R4 running period kept", n, 8);
      wait_pulse(5000, 1'b1, n);
      chk(n == 128, "R4 new ratio next period", n, 128);
      ratio_sel = 3'd0;
      wait_pulse(5000, 1'b1, n);
      chk(n == 128, "R4 downward change kept", n, 128);
      wait_pulse(5000, 1'b1, n);
      chk(n == 8, "R4 downward change applied", n, 8);
   endtask

   // R5: a select glitch between reloads is ignored
   task automatic t_glitch();
      int n;
      apply_reset(3'd1);
      wait_pulse(5000, 1'b0, n);
      repeat (10) @(negedge clk);
      ratio_sel = 3'd7;
      repeat (5) @(negedge clk);
      ratio_sel = 3'd0;
      repeat (5) @(negedge clk);
      ratio_sel = 3'd1;
      wait_pulse(5000, 1'b0, n);
      chk(n == 64 - 20, "R5 glitch period", n + 20, 64);
      wait_pulse(5000, 1'b1, n);
      chk(n == 64, "R5 period after glitch", n, 64);
   endtask

   // R6: reset in mid-run restarts from a fresh load
   task automatic t_reset_midrun();
      int n;
      apply_reset(3'd3);
      repeat (100) @(negedge clk);
      ratio_sel = 3'd4;
      apply_reset(3'd4);
      wait_pulse(5000, 1'b0, n);
      chk(n == 513, "R6 restart first strobe", n, 513);
      wait_pulse(5000, 1'b1, n);
      chk(n == 512, "R6 restart period", n, 512);
   endtask

   initial begin
      @(negedge clk);
      chk(ref_pulse == 1'b0, "R6 reset state", int'(ref_pulse), 0);
      t_all_ratios();
      t_switch();
      t_glitch();
      t_reset_midrun();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule